// File: doc/BRIEF.md
# Fine-Plus-Coarse Interval Reconstructor

This block turns one measurement record from a time-to-digital converter into a signed time interval expressed in output LSBs. A record carries an angle code for the start event, an angle code for the stop event, the number of whole oscillator periods that elapsed between them, an overflow flag from the period counter, and a valid bit. Each angle code is mapped to a calibrated time bin through a table of bin boundaries. The boundaries are not evenly spaced, so the mapping corrects for an oscillator whose angular speed changes within a period.

The interval is the stop bin minus the start bin, plus the period count times the number of bins per period. Angle zero lines up with the edge on which the period counter advances, so no extra offset is added. The bin difference can be negative, and the sum is still exact across period boundaries. A calibration engine writes the boundary table through a simple write port. After reset the table holds evenly spaced boundaries. Records can arrive on every clock, and each result appears a fixed number of cycles later.

Top module: `tdc_interval_join`

## Requirements
- R1: For a valid record without overflow, `out_interval` equals coarse × NBINS + bin(stop) − bin(start) as a signed OUT_W-bit two's complement value, with NBINS = 650 by default.
- R2: bin(code) is the highest index i in 0..NBINS-1 whose boundary entry is ≤ code. This assumes a non-decreasing table with entry 0 equal to 0. A code equal to a boundary maps to that boundary's index, and a code one below it maps to the index before.
- R3: Each result appears on the outputs exactly BIN_W+1 rising clock edges after its record is sampled, where BIN_W = clog2(NBINS). Records on consecutive cycles each produce their own result.
- R4: When the stop bin is below the start bin, the negative fine difference is added with its sign. For example, coarse 1 with bins 600 and 10 gives 60, and coarse 0 with bins 600 and 10 gives −590.
- R5: A valid record with `in_ovf` high gives `out_ovf` = 1 and `out_valid` = 0 at the result cycle.
- R6: During and after synchronous active-low reset, `out_valid`, `out_ovf` and `out_interval` are 0. The table is loaded with entry i = floor(i·2^ANG_W / NBINS).
- R7: A cycle with `tbl_we` high stores `tbl_data` into entry `tbl_addr` when `tbl_addr` < NBINS. Records sampled on later cycles use the new entry, and writes to addresses ≥ NBINS change nothing.
- R8: A cycle with `in_valid` low gives `out_valid` = 0 and `out_ovf` = 0 at its result cycle, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Record present this cycle |
| in_ovf | input | 1 | Period counter overflowed for this record |
| in_coarse | input | CNT_W | Whole periods elapsed between start and stop |
| in_start_ang | input | ANG_W | Angle code of the start event |
| in_stop_ang | input | ANG_W | Angle code of the stop event |
| tbl_we | input | 1 | Boundary table write strobe |
| tbl_addr | input | BIN_W | Boundary table entry index |
| tbl_data | input | ANG_W | Boundary value to store |
| out_valid | output | 1 | Interval result valid |
| out_ovf | output | 1 | Result discarded because of counter overflow |
| out_interval | output | OUT_W | Signed interval in LSBs, two's complement |

## Verification
Hand-picked records probe the default evenly spaced table at both ends of the code range and on either side of a boundary, which separates an off-by-one in the search from a correct one. A stop bin below the start bin, with and without a whole period added, separates signed from unsigned handling of the fine difference. A maximum period count shows whether the top bits of the coarse product survive. A jittered table written through the port, followed by a long run of random back-to-back records with scattered idle and overflow cycles, checks that every stage reads the current table and that results never slip by a cycle or merge with their neighbours.

// File: rtl/tdc_join_pkg.sv
// Package: tdc_join_pkg
// Helper functions shared by the interval reconstructor modules.
// Assumes callers pass positive bin counts and angle widths below 31.
package tdc_join_pkg;

    // Boundary of bin idx in an evenly spaced table of nbins over 2^angw codes.
    function automatic int uniform_bound(input int idx, input int nbins, input int angw);
        return (idx * (1 << angw)) / nbins;
    endfunction

endpackage

// File: rtl/tdc_bin_probe.sv
// Module: tdc_bin_probe
// One step of the pipelined binary search, run on the start and stop codes
// side by side. It proposes a candidate index by setting bit BIT of the index
// found so far. The parent reads that candidate's boundary from the table.
// The candidate is kept when it is in range and its boundary does not exceed
// the code. Other record fields pass through one register stage.
// Assumes the table is non-decreasing and the parent supplies the boundary
// of o_cand_* in the same cycle.
module tdc_bin_probe #(
    parameter int ANG_W = 12,
    parameter int CNT_W = 9,
    parameter int NBINS = 650,
    parameter int BIN_W = 10,
    parameter int BIT   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_vld,
    input  logic             i_ovf,
    input  logic [CNT_W-1:0] i_coarse,
    input  logic [ANG_W-1:0] i_ang_a,
    input  logic [ANG_W-1:0] i_ang_b,
    input  logic [BIN_W-1:0] i_idx_a,
    input  logic [BIN_W-1:0] i_idx_b,
    input  logic [ANG_W-1:0] i_bnd_a,
    input  logic [ANG_W-1:0] i_bnd_b,
    output logic [BIN_W-1:0] o_cand_a,
    output logic [BIN_W-1:0] o_cand_b,
    output logic             o_vld,
    output logic             o_ovf,
    output logic [CNT_W-1:0] o_coarse,
    output logic [ANG_W-1:0] o_ang_a,
    output logic [ANG_W-1:0] o_ang_b,
    output logic [BIN_W-1:0] o_idx_a,
    output logic [BIN_W-1:0] o_idx_b
);

    localparam logic [BIN_W-1:0] STEP = BIN_W'(1) << BIT;

    logic take_a;
    logic take_b;

    // Candidate indices and the decision to keep each one.
    always_comb begin
        o_cand_a = i_idx_a | STEP;
        o_cand_b = i_idx_b | STEP;
        take_a   = (int'(o_cand_a) < NBINS) && (i_bnd_a <= i_ang_a);
        take_b   = (int'(o_cand_b) < NBINS) && (i_bnd_b <= i_ang_b);
    end

    // Register the refined indices and pass the record along.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld    <= 1'b0;
            o_ovf    <= 1'b0;
            o_coarse <= '0;
            o_ang_a  <= '0;
            o_ang_b  <= '0;
            o_idx_a  <= '0;
            o_idx_b  <= '0;
        end else begin
            o_vld    <= i_vld;
            o_ovf    <= i_ovf;
            o_coarse <= i_coarse;
            o_ang_a  <= i_ang_a;
            o_ang_b  <= i_ang_b;
            o_idx_a  <= take_a ? o_cand_a : i_idx_a;
            o_idx_b  <= take_b ? o_cand_b : i_idx_b;
        end
    end

    // R2: a search step never leaves the table's index range.
    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> (int'(o_idx_a) < NBINS) && (int'(o_idx_b) < NBINS));

endmodule

// File: rtl/tdc_span_sum.sv
// Module: tdc_span_sum
// Final stage. It adds the period count times the bins per period to the
// signed difference of the two bins and registers the result. A record whose
// counter overflowed is flagged and not marked valid.
// Assumes the bin indices are below NBINS and that OUT_W holds the largest sum.
module tdc_span_sum #(
    parameter int CNT_W = 9,
    parameter int NBINS = 650,
    parameter int BIN_W = 10,
    parameter int OUT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_vld,
    input  logic             i_ovf,
    input  logic [CNT_W-1:0] i_coarse,
    input  logic [BIN_W-1:0] i_idx_a,
    input  logic [BIN_W-1:0] i_idx_b,
    output logic             out_valid,
    output logic             out_ovf,
    output logic [OUT_W-1:0] out_interval
);

    localparam logic [OUT_W-1:0] PERIOD_LSB = OUT_W'(NBINS);

    logic [OUT_W-1:0] coarse_term;
    logic [OUT_W-1:0] fine_term;
    logic             keep;

    // Coarse product and wrapped fine difference; modular sum is exact.
    always_comb begin
        coarse_term = OUT_W'(i_coarse) * PERIOD_LSB;
        fine_term   = OUT_W'(i_idx_b) - OUT_W'(i_idx_a);
        keep        = i_vld && !i_ovf;
    end

    // Register the interval, its valid flag and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_ovf      <= 1'b0;
            out_interval <= '0;
        end else begin
            out_valid    <= keep;
            out_ovf      <= i_vld && i_ovf;
            out_interval <= keep ? (coarse_term + fine_term) : '0;
        end
    end

    // R5: an overflowed record is never reported as valid.
    a_r5_ovf_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> !out_valid);

    // R8: a result is valid only if a valid record without overflow arrived.
    a_r8_valid_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(i_vld) && !$past(i_ovf));

endmodule

// File: rtl/tdc_interval_join.sv
// Module: tdc_interval_join
// Top of the interval reconstructor. It holds the calibrated boundary table,
// which resets to even spacing and is rewritten through a write port. It runs
// BIN_W search steps on the start and stop codes, one register each, then the
// summing stage. Latency is BIN_W+1 cycles and a record can enter every cycle.
// Assumes the table is not written while records are in flight and that the
// table is non-decreasing with entry 0 equal to 0.
module tdc_interval_join #(
    parameter int ANG_W = 12,
    parameter int CNT_W = 9,
    parameter int NBINS = 650,
    parameter int OUT_W = 20,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_ovf,
    input  logic [CNT_W-1:0] in_coarse,
    input  logic [ANG_W-1:0] in_start_ang,
    input  logic [ANG_W-1:0] in_stop_ang,
    input  logic             tbl_we,
    input  logic [BIN_W-1:0] tbl_addr,
    input  logic [ANG_W-1:0] tbl_data,
    output logic             out_valid,
    output logic             out_ovf,
    output logic [OUT_W-1:0] out_interval
);

    localparam int NSTEP = BIN_W;

    logic [ANG_W-1:0] bnd_q [NBINS];

    logic             pv   [NSTEP+1];
    logic             po   [NSTEP+1];
    logic [CNT_W-1:0] pc   [NSTEP+1];
    logic [ANG_W-1:0] pa   [NSTEP+1];
    logic [ANG_W-1:0] pb   [NSTEP+1];
    logic [BIN_W-1:0] pia  [NSTEP+1];
    logic [BIN_W-1:0] pib  [NSTEP+1];
    logic [BIN_W-1:0] cand_a [NSTEP];
    logic [BIN_W-1:0] cand_b [NSTEP];
    logic [ANG_W-1:0] rd_a   [NSTEP];
    logic [ANG_W-1:0] rd_b   [NSTEP];

    // Boundary table: even spacing at reset, then calibration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBINS; i++) begin
                bnd_q[i] <= ANG_W'(tdc_join_pkg::uniform_bound(i, NBINS, ANG_W));
            end
        end else if (tbl_we && (int'(tbl_addr) < NBINS)) begin
            bnd_q[tbl_addr] <= tbl_data;
        end
    end

    // Stage-0 view of the incoming record with empty search indices.
    always_comb begin
        pv[0]  = in_valid;
        po[0]  = in_ovf;
        pc[0]  = in_coarse;
        pa[0]  = in_start_ang;
        pb[0]  = in_stop_ang;
        pia[0] = '0;
        pib[0] = '0;
    end

    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        // Boundary reads for this step's candidates, clipped into range.
        assign rd_a[g] = bnd_q[(int'(cand_a[g]) < NBINS) ? cand_a[g] : '0];
        assign rd_b[g] = bnd_q[(int'(cand_b[g]) < NBINS) ? cand_b[g] : '0];

        tdc_bin_probe #(
            .ANG_W (ANG_W),
            .CNT_W (CNT_W),
            .NBINS (NBINS),
            .BIN_W (BIN_W),
            .BIT   (NSTEP - 1 - g)
        ) u_probe (
            .clk      (clk),
            .rst_n    (rst_n),
            .i_vld    (pv[g]),
            .i_ovf    (po[g]),
            .i_coarse (pc[g]),
            .i_ang_a  (pa[g]),
            .i_ang_b  (pb[g]),
            .i_idx_a  (pia[g]),
            .i_idx_b  (pib[g]),
            .i_bnd_a  (rd_a[g]),
            .i_bnd_b  (rd_b[g]),
            .o_cand_a (cand_a[g]),
            .o_cand_b (cand_b[g]),
            .o_vld    (pv[g+1]),
            .o_ovf    (po[g+1]),
            .o_coarse (pc[g+1]),
            .o_ang_a  (pa[g+1]),
            .o_ang_b  (pb[g+1]),
            .o_idx_a  (pia[g+1]),
            .o_idx_b  (pib[g+1])
        );
    end

    tdc_span_sum #(
        .CNT_W (CNT_W),
        .NBINS (NBINS),
        .BIN_W (BIN_W),
        .OUT_W (OUT_W)
    ) u_sum (
        .clk          (clk),
        .rst_n        (rst_n),
        .i_vld        (pv[NSTEP]),
        .i_ovf        (po[NSTEP]),
        .i_coarse     (pc[NSTEP]),
        .i_idx_a      (pia[NSTEP]),
        .i_idx_b      (pib[NSTEP]),
        .out_valid    (out_valid),
        .out_ovf      (out_ovf),
        .out_interval (out_interval)
    );

    // Neighbour entries of the final bins, used by the search checks.
    logic [BIN_W-1:0] nxt_a;
    logic [BIN_W-1:0] nxt_b;
    logic [BIN_W-1:0] nxt_ac;
    logic [BIN_W-1:0] nxt_bc;
    logic [BIN_W-1:0] fin_ac;
    logic [BIN_W-1:0] fin_bc;
    assign nxt_a  = pia[NSTEP] + BIN_W'(1);
    assign nxt_b  = pib[NSTEP] + BIN_W'(1);
    assign nxt_ac = (int'(nxt_a) < NBINS) ? nxt_a : '0;
    assign nxt_bc = (int'(nxt_b) < NBINS) ? nxt_b : '0;
    assign fin_ac = (int'(pia[NSTEP]) < NBINS) ? pia[NSTEP] : '0;
    assign fin_bc = (int'(pib[NSTEP]) < NBINS) ? pib[NSTEP] : '0;

    // R2: the chosen bin's boundary does not exceed its code.
    a_r2_bound_le_code: assert property (@(posedge clk) disable iff (!rst_n)
        pv[NSTEP] |-> (bnd_q[fin_ac] <= pa[NSTEP]) && (bnd_q[fin_bc] <= pb[NSTEP]));

    // R2: the next bin's boundary lies above the code (highest match taken).
    a_r2_next_bound_gt: assert property (@(posedge clk) disable iff (!rst_n)
        (pv[NSTEP] && (int'(nxt_a) < NBINS)) |-> (bnd_q[nxt_ac] > pa[NSTEP]));

endmodule

// File: tb/tb_tdc_interval_join.sv
module tb_tdc_interval_join;

    localparam int CLK_PERIOD = 10;
    localparam int ANG_W = 12;
    localparam int CNT_W = 9;
    localparam int NBINS = 650;
    localparam int OUT_W = 20;
    localparam int BIN_W = $clog2(NBINS);
    localparam int LAT   = BIN_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ovf = 1'b0;
    logic [CNT_W-1:0] in_coarse = '0;
    logic [ANG_W-1:0] in_start_ang = '0;
    logic [ANG_W-1:0] in_stop_ang = '0;
    logic             tbl_we = 1'b0;
    logic [BIN_W-1:0] tbl_addr = '0;
    logic [ANG_W-1:0] tbl_data = '0;
    logic             out_valid;
    logic             out_ovf;
    logic [OUT_W-1:0] out_interval;

    tdc_interval_join #(
        .ANG_W (ANG_W), .CNT_W (CNT_W), .NBINS (NBINS), .OUT_W (OUT_W)
    ) dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ovf (in_ovf),
        .in_coarse (in_coarse), .in_start_ang (in_start_ang),
        .in_stop_ang (in_stop_ang), .tbl_we (tbl_we), .tbl_addr (tbl_addr),
        .tbl_data (tbl_data), .out_valid (out_valid), .out_ovf (out_ovf),
        .out_interval (out_interval)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    int    tb_tbl [NBINS];
    bit    ex_v   [16];
    bit    ex_o   [16];
    int    ex_val [16];
    string ex_tag [16];

    // Expected bin: highest index whose boundary is <= code.
    function automatic int bin_of(input int code);
        int r = 0;
        for (int i = 0; i < NBINS; i++) if (tb_tbl[i] <= code) r = i;
        return r;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // One cycle: check the result due now, then drive a new record.
    task automatic step(input bit v, input bit o, input int c, input int a,
                        input int b, input string tag);
        int s;
        @(negedge clk);
        s = (cyc + 16 - LAT) % 16;
        check(ex_tag[s], "out_valid", int'(out_valid), int'(ex_v[s]));
        check(ex_tag[s], "out_ovf", int'(out_ovf), int'(ex_o[s]));
        if (ex_v[s]) check(ex_tag[s], "interval", int'($signed(out_interval)), ex_val[s]);
        in_valid     = v;
        in_ovf       = o;
        in_coarse    = CNT_W'(c);
        in_start_ang = ANG_W'(a);
        in_stop_ang  = ANG_W'(b);
        s = cyc % 16;
        ex_v[s]   = v && !o;
        ex_o[s]   = v && o;
        ex_val[s] = c * NBINS + bin_of(b) - bin_of(a);
        ex_tag[s] = v ? tag : "R8";
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 0, "R8");
    endtask

    // Table write through the port (R7); model follows the same rule.
    task automatic wr_tbl(input int addr, input int data);
        tbl_we   = 1'b1;
        tbl_addr = BIN_W'(addr);
        tbl_data = ANG_W'(data);
        step(1'b0, 1'b0, 0, 0, 0, "R8");
        if (addr < NBINS) tb_tbl[addr] = data;
        tbl_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin
            ex_v[i] = 1'b0; ex_o[i] = 1'b0; ex_val[i] = 0; ex_tag[i] = "R8";
        end
        for (int i = 0; i < NBINS; i++) tb_tbl[i] = (i * (1 << ANG_W)) / NBINS;

        // R6: reset state of the outputs.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6", "out_valid", int'(out_valid), 0);
        check("R6", "out_ovf", int'(out_ovf), 0);
        check("R6", "interval", int'(out_interval), 0);
        rst_n = 1'b1;

        // R6: default evenly spaced table at the ends of the code range.
        step(1'b1, 1'b0, 0, 0, 0, "R6");
        step(1'b1, 1'b0, 1, 4095, 0, "R6");
        step(1'b1, 1'b0, 0, 0, 4095, "R6");
        // R2: codes on and just below a boundary.
        step(1'b1, 1'b0, 0, tb_tbl[100] - 1, tb_tbl[100], "R2");
        step(1'b1, 1'b0, 2, tb_tbl[300], tb_tbl[301] - 1, "R2");
        // R4: negative fine difference, with and without a period added.
        step(1'b1, 1'b0, 1, tb_tbl[600], tb_tbl[10], "R4");
        step(1'b1, 1'b0, 0, tb_tbl[600], tb_tbl[10], "R4");
        // R1: largest period count with largest fine span.
        step(1'b1, 1'b0, 511, 0, 4095, "R1");
        // R5: overflow flagged, result not valid.
        step(1'b1, 1'b1, 7, 100, 200, "R5");
        // R8: idle cycle carrying overflow and data is ignored.
        step(1'b0, 1'b1, 9, 300, 400, "R8");
        // R3: back-to-back burst of distinct records.
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, i * 13, i * 197, 4095 - i * 151, "R3");
        idle(LAT);

        // R7: write a jittered non-uniform table, plus an out-of-range write.
        for (int i = 0; i < NBINS; i++) begin
            int u;
            u = (i * (1 << ANG_W)) / NBINS;
            if (i > 0) u = u + int'($urandom % 5) - 2;
            if (i == 0) u = 0;
            if (i > 0 && u < tb_tbl[i-1]) u = tb_tbl[i-1];
            if (u > 4095) u = 4095;
            wr_tbl(i, u);
        end
        wr_tbl(700, 5);
        step(1'b1, 1'b0, 0, tb_tbl[1], tb_tbl[2] - 1, "R7");
        step(1'b1, 1'b0, 3, tb_tbl[649], tb_tbl[5], "R7");
        step(1'b1, 1'b0, 0, tb_tbl[1] - 1, tb_tbl[648], "R7");

        // R1: random records with scattered idle and overflow cycles.
        for (int i = 0; i < 1500; i++) begin
            bit v;
            bit o;
            v = ($urandom % 10) < 9;
            o = ($urandom % 20) == 0;
            step(v, o, int'($urandom % 512), int'($urandom % 4096),
                 int'($urandom % 4096), o ? "R5" : "R1");
        end
        idle(LAT + 2);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule